// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block turns single read or write requests into the command stream of a two-bank synchronous DRAM with 8-bit words, 4096 rows and 512 columns per bank. Each request carries a flat address, a direction bit and an auto-close bit. The sequencer opens the addressed row when needed. It closes a conflicting row first and then issues the column command. It also keeps every spacing rule of the part, each one given as a cycle-count parameter. A request is accepted in the cycle in which the sequencer can issue its column command. The read and write data paths are handled outside this block.

Around the user traffic it runs four housekeeping jobs. At power-up it brings the memory up and programs the mode register. A free-running timer triggers periodic refresh, which always takes precedence over user traffic. When one of these jobs needs the banks idle, it closes every bank with a single close-all command. While the power-down request is held and no request is waiting, the sequencer parks the memory in power-down. It wakes the memory when a refresh falls due, when a request arrives, or when the power-down request is released.

Top module: `sdc_ctrl`

## Requirements
- R1: After reset the memory pins carry only NOP for at least T_INIT-1 cycles. Then, in order: close-all, refresh, refresh, mode-register write. The mode-register write carries an address word whose bits 2:0 hold log2(BL), bit 3 is 0 (sequential order), bits 6:4 hold CL and the higher bits are 0. DQM stays high until the mode-register write has been issued.
- R2: A read or write to a bank follows that bank's activate by at least T_RCD cycles.
- R3: On the same bank, an activate follows a close by at least T_RP cycles and follows the previous activate by at least T_RC cycles. No command follows a refresh by fewer than T_RC cycles. At most one command is issued per cycle.
- R4: A close of a bank follows a write to that bank by at least BL+T_WR cycles.
- R5: A read or write with address bit 10 high leaves its bank closed, and that bank's next activate comes at least BL+T_RP cycles later (BL+T_WR+T_RP after a write). With bit 10 low the row stays open, and a second request to the same row is served without a new activate.
- R6: Refresh is issued only when both banks are closed, and successive refreshes are at most T_REFI+40 cycles apart even under continuous user traffic. Open banks are closed with close-all before the refresh.
- R7: A close command with address bit 10 low closes only the bank on the bank-select pin. With bit 10 high it closes both banks.
- R8: No command follows a mode-register write by fewer than T_MRD cycles.
- R9: CKE goes low only when both banks are closed. While CKE is low the pins carry only NOP. After CKE returns high, no command is issued for T_XP cycles. The memory wakes when a refresh falls due, when a request arrives, or when pd_req falls.
- R10: A request is taken in a cycle where req_valid and req_ready are both high. In the next cycle the pins carry a read (req_write=0) or write (req_write=1) with bank req_addr[21], column req_addr[8:0] on address bits 8:0, and address bit 10 equal to req_ap. The row is req_addr[20:9]. The command codes on {cs_n,ras_n,cas_n,we_n} are: NOP 0111, activate 0011, read 0101, write 0100, close 0010, refresh 0001, mode write 0000. req_ready is low in reset and during power-up.
- R11: DQM is high in every cycle that carries a close command.
- R12: Successive reads or writes are at least BL cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the bank after the burst |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| pd_req | input | 1 | Enter power-down when idle |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_ba | output | BA_W | Bank select |
| mem_addr | output | ROW_W | Row, column or mode word; bit 10 is the close flag |
| mem_dqm | output | 1 | Data mask |

## Verification
The hardest case to reach from the ports is a refresh that falls due while a bank holds an open row with write recovery still running. In that case close-all must wait out the recovery, and the refresh must then wait out the precharge. A related hard case is a refresh falling due in the middle of power-down. The stimulus runs a long sweep over both banks, three rows, both directions and both auto-close settings, with a short refresh period, so the refresh timer expires at many different points in the traffic. It then holds the power-down request across several refresh periods and sends a request while the memory is parked.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {ST_WAIT, ST_REF1, ST_REF2, ST_MRS, ST_RUN, ST_PD} st_e;

  // one cycle closer to zero, saturating
  function automatic cnt_t cnt_step(cnt_t c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // keep the later of the running wait and a new gap of 'gap' cycles
  function automatic cnt_t cnt_hold(cnt_t c, int gap);
    cnt_t s;
    cnt_t g;
    s = cnt_step(c);
    g = CNT_W'(gap - 1);
    return (g > s) ? g : s;
  endfunction

  // mode word: burst length code in bits 2:0, sequential order, latency in 6:4
  function automatic int mode_word(int bl, int cl);
    int lb;
    lb = 0;
    for (int i = 0; i < 8; i++) if ((1 << i) < bl) lb = i + 1;
    return (cl << 4) | lb;
  endfunction
endpackage

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RC  = 6,
  parameter int T_WR  = 2,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_col,
  input  logic             col_wr,
  input  logic             col_ap,
  input  logic             do_pre,
  input  logic             do_ref,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rw_ok,
  output logic             pre_ok,
  output logic             act_ok
);
  localparam int RD_TO_PRE = BL;
  localparam int WR_TO_PRE = BL + T_WR;
  localparam int RD_AP_ACT = BL + T_RP;
  localparam int WR_AP_ACT = BL + T_WR + T_RP;

  cnt_t c_rw, c_pre, c_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      c_rw     <= '0;
      c_pre    <= '0;
      c_act    <= '0;
    end else begin
      c_rw  <= cnt_step(c_rw);
      c_pre <= cnt_step(c_pre);
      c_act <= cnt_step(c_act);
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= act_row;
        c_rw     <= cnt_hold(c_rw, T_RCD);
        c_pre    <= cnt_hold(c_pre, T_RCD);
        c_act    <= cnt_hold(c_act, T_RC);
      end
      if (do_col) begin
        c_pre <= cnt_hold(c_pre, col_wr ? WR_TO_PRE : RD_TO_PRE);
        if (col_ap) begin
          is_open <= 1'b0;
          c_act   <= cnt_hold(c_act, col_wr ? WR_AP_ACT : RD_AP_ACT);
        end
      end
      if (do_pre) begin
        is_open <= 1'b0;
        c_act   <= cnt_hold(c_act, T_RP);
      end
      if (do_ref) c_act <= cnt_hold(c_act, T_RC);
    end
  end

  assign rw_ok  = (c_rw == '0);
  assign pre_ok = (c_pre == '0);
  assign act_ok = (c_act == '0);
endmodule

// File: rtl/sdc_refresh.sv
module sdc_refresh #(
  parameter int T_REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_due
);
  localparam int RW = $clog2(T_REFI + 1);

  logic [RW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= RW'(T_REFI - 1);
      ref_due <= 1'b0;
    end else begin
      if (ref_done) ref_due <= 1'b0;
      if (tick == '0) begin
        tick    <= RW'(T_REFI - 1);
        ref_due <= 1'b1;
      end else begin
        tick <= tick - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int BA_W   = 1,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int T_INIT = 20000,
  parameter int T_REFI = 1560,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RC   = 7,
  parameter int T_WR   = 2,
  parameter int T_MRD  = 2,
  parameter int T_XP   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_ap,
  input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
  input  logic                        pd_req,
  output logic                        mem_cke,
  output logic                        mem_cs_n,
  output logic                        mem_ras_n,
  output logic                        mem_cas_n,
  output logic                        mem_we_n,
  output logic [BA_W-1:0]             mem_ba,
  output logic [ROW_W-1:0]            mem_addr,
  output logic                        mem_dqm
);
  localparam int NB = 1 << BA_W;
  localparam int IW = $clog2(T_INIT + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(mode_word(BL, CL));

  // request fields
  logic [BA_W-1:0]  req_ba;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_ba  = req_addr[BA_W+ROW_W+COL_W-1 -: BA_W];
  assign req_row = req_addr[COL_W +: ROW_W];
  assign req_col = req_addr[COL_W-1:0];

  // per-bank state
  logic [NB-1:0]    b_open, b_rw_ok, b_pre_ok, b_act_ok;
  logic [ROW_W-1:0] b_row [NB];

  // command events, named for the checker
  logic iss_act, iss_col, iss_pre, iss_pall, iss_ref, iss_mrs, pd_enter, pd_exit;
  logic in_run, ref_due, quiesce, hit, col_ok, gen_ok;

  st_e            state;
  logic [IW-1:0]  init_cnt;
  cnt_t           c_gen, c_col;
  cmd_e           cmd_n, cmd_q;
  logic [BA_W-1:0]  ba_n;
  logic [ROW_W-1:0] addr_n;
  logic           cke_q, dqm_q;

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    logic sel;
    assign sel = (req_ba == BA_W'(gi));
    sdc_bank #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR), .BL(BL)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_act  (iss_act & sel),
      .do_col  (iss_col & sel),
      .col_wr  (req_write),
      .col_ap  (req_ap),
      .do_pre  (iss_pall | (iss_pre & sel)),
      .do_ref  (iss_ref),
      .act_row (req_row),
      .is_open (b_open[gi]),
      .open_row(b_row[gi]),
      .rw_ok   (b_rw_ok[gi]),
      .pre_ok  (b_pre_ok[gi]),
      .act_ok  (b_act_ok[gi])
    );
  end

  sdc_refresh #(.T_REFI(T_REFI)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_done(iss_ref),
    .ref_due (ref_due)
  );

  assign in_run    = (state == ST_RUN);
  assign gen_ok    = (c_gen == '0);
  assign quiesce   = ref_due | (pd_req & ~req_valid);
  assign hit       = b_open[req_ba] && (b_row[req_ba] == req_row);
  assign col_ok    = b_rw_ok[req_ba] && (c_col == '0) && gen_ok;
  assign req_ready = in_run && !ref_due && hit && col_ok;

  // command choice
  always_comb begin
    iss_act  = 1'b0;
    iss_col  = 1'b0;
    iss_pre  = 1'b0;
    iss_pall = 1'b0;
    iss_ref  = 1'b0;
    iss_mrs  = 1'b0;
    pd_enter = 1'b0;
    pd_exit  = 1'b0;
    unique case (state)
      ST_WAIT: iss_pall = (init_cnt == '0);
      ST_REF1, ST_REF2: iss_ref = gen_ok;
      ST_MRS: iss_mrs = gen_ok;
      ST_RUN: begin
        if (quiesce) begin
          if (|b_open) iss_pall = (&b_pre_ok) && gen_ok;
          else if (ref_due) iss_ref = (&b_act_ok) && gen_ok;
          else pd_enter = gen_ok;
        end else if (req_valid) begin
          if (hit) iss_col = col_ok;
          else if (b_open[req_ba]) iss_pre = b_pre_ok[req_ba] && gen_ok;
          else iss_act = b_act_ok[req_ba] && gen_ok;
        end
      end
      ST_PD: pd_exit = !pd_req || ref_due || req_valid;
      default: ;
    endcase
  end

  // command encoding onto the pins
  always_comb begin
    cmd_n  = CMD_NOP;
    ba_n   = '0;
    addr_n = '0;
    if (iss_act) begin
      cmd_n  = CMD_ACT;
      ba_n   = req_ba;
      addr_n = req_row;
    end else if (iss_col) begin
      cmd_n  = req_write ? CMD_WR : CMD_RD;
      ba_n   = req_ba;
      addr_n[COL_W-1:0] = req_col;
      addr_n[AP_BIT]    = req_ap;
    end else if (iss_pre) begin
      cmd_n  = CMD_PRE;
      ba_n   = req_ba;
    end else if (iss_pall) begin
      cmd_n  = CMD_PRE;
      addr_n[AP_BIT] = 1'b1;
    end else if (iss_ref) begin
      cmd_n  = CMD_REF;
    end else if (iss_mrs) begin
      cmd_n  = CMD_MRS;
      addr_n = MODE_WORD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WAIT;
      init_cnt <= IW'(T_INIT - 1);
      c_gen    <= '0;
      c_col    <= '0;
      cke_q    <= 1'b1;
      dqm_q    <= 1'b1;
      cmd_q    <= CMD_NOP;
      mem_ba   <= '0;
      mem_addr <= '0;
    end else begin
      if (init_cnt != '0) init_cnt <= init_cnt - 1'b1;
      c_gen <= cnt_step(c_gen);
      c_col <= cnt_step(c_col);
      if (iss_pall) c_gen <= cnt_hold(c_gen, T_RP);
      if (iss_ref)  c_gen <= cnt_hold(c_gen, T_RC);
      if (iss_mrs)  c_gen <= cnt_hold(c_gen, T_MRD);
      if (pd_exit)  c_gen <= cnt_hold(c_gen, T_XP);
      if (iss_col)  c_col <= cnt_hold(c_col, BL);

      unique case (state)
        ST_WAIT: if (iss_pall) state <= ST_REF1;
        ST_REF1: if (iss_ref) state <= ST_REF2;
        ST_REF2: if (iss_ref) state <= ST_MRS;
        ST_MRS:  if (iss_mrs) state <= ST_RUN;
        ST_RUN:  if (pd_enter) begin state <= ST_PD;  cke_q <= 1'b0; end
        ST_PD:   if (pd_exit)  begin state <= ST_RUN; cke_q <= 1'b1; end
        default: state <= ST_WAIT;
      endcase

      cmd_q    <= cmd_n;
      mem_ba   <= ba_n;
      mem_addr <= addr_n;
      dqm_q    <= (state != ST_RUN && state != ST_PD) | iss_pall | iss_pre;
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_cke = cke_q;
  assign mem_dqm = dqm_q;
endmodule

// File: rtl/sdc_ctrl_chk.sv
module sdc_ctrl_chk
  import sdc_pkg::*;
#(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_cke,
  input logic          mem_dqm,
  input logic [3:0]    pins_cmd,
  input logic          a10,
  input logic [NB-1:0] bank_open,
  input logic          req_valid,
  input logic          req_ready,
  input logic          in_run,
  input logic          iss_act,
  input logic          iss_col,
  input logic          iss_pre,
  input logic          iss_pall,
  input logic          iss_ref,
  input logic          iss_mrs
);
  // R9
  cke_low_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> bank_open == '0);

  // R9
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> pins_cmd == CMD_NOP);

  // R10
  ready_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> in_run);

  // R10
  accept_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (pins_cmd == CMD_RD || pins_cmd == CMD_WR));

  // R11
  close_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_cmd == CMD_PRE |-> mem_dqm);

  // R7
  close_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_cmd == CMD_PRE && a10 |-> bank_open == '0);

  // R6
  refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_cmd == CMD_REF |-> bank_open == '0);

  // R3
  one_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iss_act, iss_col, iss_pre, iss_pall, iss_ref, iss_mrs}));
endmodule

bind sdc_ctrl sdc_ctrl_chk #(.NB(NB)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_cke  (mem_cke),
  .mem_dqm  (mem_dqm),
  .pins_cmd ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}),
  .a10      (mem_addr[AP_BIT]),
  .bank_open(b_open),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .in_run   (in_run),
  .iss_act  (iss_act),
  .iss_col  (iss_col),
  .iss_pre  (iss_pre),
  .iss_pall (iss_pall),
  .iss_ref  (iss_ref),
  .iss_mrs  (iss_mrs)
);

// File: tb/sdc_ctrl_tb.sv
`timescale 1ns/1ps
module sdc_ctrl_tb_top;
  localparam int BL = 4, CL = 2, T_INIT = 12, T_REFI = 180;
  localparam int T_RCD = 2, T_RP = 2, T_RC = 6, T_WR = 2, T_MRD = 2, T_XP = 2;
  localparam int SLACK = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0, pd_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic req_ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dqm;
  logic [0:0] mem_ba;
  logic [11:0] mem_addr;

  always #2 clk = ~clk;

  sdc_ctrl #(
    .BL(BL), .CL(CL), .T_INIT(T_INIT), .T_REFI(T_REFI), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD), .T_XP(T_XP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ap(req_ap), .req_addr(req_addr), .pd_req(pd_req),
    .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_dqm(mem_dqm)
  );

  int vectors = 0, fails = 0, cyc = 0, wd = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int expected_mode();
    int lb = 0;
    while ((1 << lb) < BL) lb++;
    return CL * 16 + lb;
  endfunction

  // monitor state
  bit open_b [2];
  int act_ok [2], rw_ok [2], pre_ok [2];
  int col_ok = 0, gen_ok = 0, xp_ok = 0, last_ref = 0;
  int n_ref = 0, n_act = 0, pd_cycles = 0, init_step = 0;
  string gen_tag = "R3";
  bit init_done = 0, prev_cke = 1;
  bit exp_v = 0, exp_w, exp_ap;
  int exp_ba, exp_col;

  always @(negedge clk) begin
    logic [3:0] cmd;
    int b;
    cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    b = int'(mem_ba);
    if (!rst_n) begin
      chk(cmd == 4'b0111, "R1", "command in reset", cmd, 4'b0111);
      chk(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
    end else if (!finished) begin
      if (exp_v) begin
        chk(cmd == (exp_w ? 4'b0100 : 4'b0101), "R10", "column command", cmd, exp_w ? 4 : 5);
        chk(b == exp_ba, "R10", "bank", b, exp_ba);
        chk(int'(mem_addr[8:0]) == exp_col, "R10", "column", mem_addr[8:0], exp_col);
        chk(mem_addr[10] == exp_ap, "R10", "close flag", mem_addr[10], exp_ap);
        exp_v = 0;
      end
      if (req_valid && req_ready) begin
        chk(init_done, "R10", "accept before power-up end", 1, 0);
        exp_v = 1; exp_w = req_write; exp_ap = req_ap;
        exp_ba = int'(req_addr[21]); exp_col = int'(req_addr[8:0]);
      end
      if (!init_done) chk(mem_dqm == 1'b1, "R1", "dqm during power-up", mem_dqm, 1);
      if (prev_cke && !mem_cke)
        chk(!open_b[0] && !open_b[1], "R9", "banks open at power-down", open_b[0] | open_b[1], 0);
      if (!prev_cke && mem_cke) xp_ok = cyc + T_XP;
      if (!mem_cke) begin
        pd_cycles++;
        chk(cmd == 4'b0111, "R9", "command while parked", cmd, 4'b0111);
      end
      prev_cke = mem_cke;

      if (cmd != 4'b0111) begin
        chk(cyc >= xp_ok, "R9", "cycle after wake", cyc, xp_ok);
        chk(cyc >= gen_ok, gen_tag, "cycle after refresh/mode", cyc, gen_ok);
        if (!init_done) begin
          case (init_step)
            0: begin
              chk(cmd == 4'b0010 && mem_addr[10], "R1", "first step close-all", cmd, 2);
              chk(cyc >= T_INIT - 1, "R1", "power-up wait", cyc, T_INIT - 1);
            end
            1, 2: chk(cmd == 4'b0001, "R1", "refresh step", cmd, 1);
            default: chk(cmd == 4'b0000, "R1", "mode step", cmd, 0);
          endcase
          init_step++;
        end
        case (cmd)
          4'b0011: begin
            n_act++;
            chk(!open_b[b], "R7", "activate on open bank", 1, 0);
            chk(cyc >= act_ok[b], "R3", "activate spacing", cyc, act_ok[b]);
            open_b[b] = 1; rw_ok[b] = cyc + T_RCD; act_ok[b] = cyc + T_RC;
          end
          4'b0100, 4'b0101: begin
            chk(open_b[b], "R5", "column on closed bank", 0, 1);
            chk(cyc >= rw_ok[b], "R2", "activate to column", cyc, rw_ok[b]);
            chk(cyc >= col_ok, "R12", "column spacing", cyc, col_ok);
            col_ok = cyc + BL;
            if (cmd == 4'b0100) pre_ok[b] = imax(pre_ok[b], cyc + BL + T_WR);
            if (mem_addr[10]) begin
              open_b[b] = 0;
              act_ok[b] = imax(act_ok[b], cyc + BL + ((cmd == 4'b0100) ? T_WR : 0) + T_RP);
            end
          end
          4'b0010: begin
            chk(mem_dqm == 1'b1, "R11", "dqm on close", mem_dqm, 1);
            for (int i = 0; i < 2; i++) begin
              if (mem_addr[10] || i == b) begin
                chk(cyc >= pre_ok[i], "R4", "write to close", cyc, pre_ok[i]);
                open_b[i] = 0;
                act_ok[i] = imax(act_ok[i], cyc + T_RP);
              end
            end
          end
          4'b0001: begin
            chk(!open_b[0] && !open_b[1], "R6", "refresh with open bank", 1, 0);
            for (int i = 0; i < 2; i++) begin
              chk(cyc >= act_ok[i], "R3", "close to refresh", cyc, act_ok[i]);
              act_ok[i] = imax(act_ok[i], cyc + T_RC);
            end
            if (init_done) chk(cyc - last_ref <= T_REFI + SLACK, "R6", "refresh gap", cyc - last_ref, T_REFI + SLACK);
            last_ref = cyc; n_ref++;
            gen_ok = cyc + T_RC; gen_tag = "R3";
          end
          4'b0000: begin
            chk(int'(mem_addr) == expected_mode(), "R1", "mode word", mem_addr, expected_mode());
            gen_ok = cyc + T_MRD; gen_tag = "R8";
            init_done = 1;
          end
          default: chk(0, "R10", "unknown command", cmd, 7);
        endcase
      end
      cyc++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic send(input int ba, input int row, input int col, input bit w, input bit ap);
    @(posedge clk); #1;
    req_addr  = {ba[0], row[11:0], col[8:0]};
    req_write = w; req_ap = ap; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    int rows [3];
    int a0, r0, refs_before;
    rows = '{3, 700, 4095};
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;

    // sweep: bank x row x close flag x direction, each with a second same-row access
    for (int ba = 0; ba < 2; ba++)
      for (int ri = 0; ri < 3; ri++)
        for (int ap = 0; ap < 2; ap++)
          for (int w = 0; w < 2; w++) begin
            send(ba, rows[ri], ri * 17 + ba, w[0], ap[0]);
            a0 = n_act; r0 = n_ref;
            send(ba, rows[ri], 511 - ri, ~w[0], 1'b0);
            repeat (2) @(negedge clk);
            if (n_ref == r0)
              chk(n_act == a0 + ap, "R5", "activates for same-row access", n_act - a0, ap);
          end

    // alternate banks and rows for conflict closes
    for (int k = 0; k < 24; k++)
      send(k % 2, (k * 97) % 4096, k * 5, k[1], k[2] & k[0]);

    // power-down across several refresh periods
    refs_before = n_ref;
    @(posedge clk); #1 pd_req = 1'b1;
    repeat (800) @(negedge clk);
    chk(pd_cycles > 0, "R9", "cycles spent parked", pd_cycles, 1);
    chk(n_ref > refs_before + 2, "R6", "refreshes while parked", n_ref - refs_before, 3);
    // wake by request while still asked to park
    send(1, 50, 3, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(!mem_cke, "R9", "parked again after request", mem_cke, 0);
    @(posedge clk); #1 pd_req = 1'b0;
    repeat (T_XP + 3) @(negedge clk);
    chk(mem_cke, "R9", "awake after release", mem_cke, 1);

    repeat (400) @(negedge clk);
    chk(n_ref >= cyc / (T_REFI + SLACK), "R6", "refresh count", n_ref, cyc / (T_REFI + SLACK));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule